// File: doc/BRIEF.md
# Fixed-Point Audio Effects ALU

This block is the arithmetic heart of a small audio effects engine. Each cycle it may accept one operation: a 4-bit operation code and three signed two's-complement operands A, X and Y. One clock edge later it presents the result R, a condition word that describes R, and the value of an internal accumulator. Sequencing, operand fetch and delay-line memory sit outside the block. The block only computes.

The operation set covers several groups. There are multiply-accumulate forms with a Q31 (fractional) or integer product, a negated product, and saturation or wraparound on overflow. There are also a three-input add, a masked bitwise combine, signed compare-and-select forms, and a fractional interpolation between A and Y. The codes reserved for log, exp and conditional skip are not implemented. They return A and leave the accumulator as it was. When the strobe is low, all registered outputs hold their values.

Top module: `fxalu_core`

## Requirements
- R1: After reset, res_o, flags_o and acc_o are zero and res_valid_o is low.
- R2: Code 0x0 gives A + (X·Y >>> 31) clamped to the signed range. Code 0x1 is the same but shifts the negated product (−X·Y) >>> 31. A clamp goes to 0x7FFFFFFF above the range and to 0x80000000 below it.
- R3: Codes 0x2 and 0x3 compute the same sums as 0x0 and 0x1 but keep the low 32 bits instead of clamping.
- R4: Code 0x4 gives A + X·Y (full integer product) clamped to the signed range. Code 0x5 keeps the low 31 bits of that sum and sign-extends bit 30 into bit 31.
- R5: Code 0x6 gives A + X + Y clamped to the signed range.
- R6: Code 0x7 returns A. It adds (X·Y >>> 31) into the accumulator, keeping the low 32 bits.
- R7: Code 0x8 returns (A AND X) XOR Y.
- R8: With signed comparison, code 0x9 returns X if A ≥ Y and otherwise NOT X. Code 0xA returns X if A ≥ Y and otherwise Y. Code 0xB returns X if A < Y and otherwise Y.
- R9: Code 0xE returns A + ((X·(Y − A)) >>> 31), with Y − A formed without loss, clamped to the signed range.
- R10: Codes 0xC, 0xD and 0xF return A, leave the accumulator unchanged and never set the saturate flag.
- R11: The 16-bit flag word is set as follows. Bit 0 is R[31] XOR R[30]. Bit 1 is signed A < Y. Bit 2 is R[31]. Bit 4 is R == 0. Bit 5 is set only when a clamp was applied. Bit 8 is R ≠ 0. All other bits are 0.
- R12: Every implemented code other than 0x7 loads the accumulator with R.
- R13: Results appear one clock after the cycle that has valid_i high, with res_valid_o high. In a cycle with valid_i low, res_valid_o goes low on the next clock and res_o, flags_o and acc_o keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| a_i | input | DW | Operand A |
| x_i | input | DW | Operand X |
| y_i | input | DW | Operand Y |
| res_o | output | DW | Registered result R |
| res_valid_o | output | 1 | High for one cycle after an accepted operation |
| flags_o | output | 16 | Condition word for R |
| acc_o | output | DW | Accumulator |

## Verification
The bench builds the block with the default DW of 32. At this width the Q31 shift is 31 and the model's operands match the flag bit positions, so the bench can drive the exact clamp limits 0x7FFFFFFF and 0x80000000. It also covers the fractional −1 × −1 product, which overflows even before A is added, and the interpolation case where Y − A needs 33 bits. It exercises the 31-bit wrap boundary at bit 30 and signed-versus-unsigned ordering in the selects. A behavioural model built on wide integers predicts R, the flag word and the accumulator for every clock, including idle cycles and reserved codes.

// File: rtl/fxalu_pkg.sv
package fxalu_pkg;

    typedef enum logic [3:0] {
        OP_MACF   = 4'h0,
        OP_MACFN  = 4'h1,
        OP_MACFW  = 4'h2,
        OP_MACFNW = 4'h3,
        OP_MACI   = 4'h4,
        OP_MACIW  = 4'h5,
        OP_ADD3   = 4'h6,
        OP_MVACC  = 4'h7,
        OP_MASKX  = 4'h8,
        OP_TSTINV = 4'h9,
        OP_SELGE  = 4'hA,
        OP_SELLT  = 4'hB,
        OP_RSV_C  = 4'hC,
        OP_RSV_D  = 4'hD,
        OP_INTERP = 4'hE,
        OP_RSV_F  = 4'hF
    } fx_op_e;

    // How a wide intermediate is fitted into the result width
    typedef enum logic [1:0] {
        FIT_SAT  = 2'd0,
        FIT_WRAP = 2'd1,
        FIT_W31  = 2'd2
    } fit_e;

    localparam int FLAG_W    = 16;
    localparam int FL_NORM   = 0;
    localparam int FL_BORROW = 1;
    localparam int FL_MINUS  = 2;
    localparam int FL_ZERO   = 4;
    localparam int FL_SAT    = 5;
    localparam int FL_NZ     = 8;

endpackage

// File: rtl/fxalu_mul.sv
module fxalu_mul #(
    parameter int AW = 32,
    parameter int BW = 32
) (
    input  logic signed [AW-1:0]    a_i,
    input  logic signed [BW-1:0]    b_i,
    output logic signed [AW+BW-1:0] p_o
);
    localparam int PW = AW + BW;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] b_ext;

    // Full sign extension: the low PW bits of the product are exact
    assign a_ext = {{BW{a_i[AW-1]}}, a_i};
    assign b_ext = {{AW{b_i[BW-1]}}, b_i};
    assign p_o   = $signed(a_ext * b_ext);

endmodule

// File: rtl/fxalu_fit.sv
module fxalu_fit
    import fxalu_pkg::*;
#(
    parameter int DW = 32,
    parameter int WW = 68
) (
    input  logic signed [WW-1:0] val_i,
    input  fit_e                 mode_i,
    output logic [DW-1:0]        res_o,
    output logic                 sat_o
);
    localparam logic signed [WW-1:0] MAXV = {{(WW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [WW-1:0] MINV = {{(WW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic [DW-1:0]        RMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0]        RMIN = {1'b1, {(DW-1){1'b0}}};

    always_comb begin
        sat_o = 1'b0;
        res_o = val_i[DW-1:0];
        case (mode_i)
            FIT_SAT: begin
                if (val_i > MAXV) begin
                    res_o = RMAX;
                    sat_o = 1'b1;
                end else if (val_i < MINV) begin
                    res_o = RMIN;
                    sat_o = 1'b1;
                end
            end
            FIT_W31:  res_o = {val_i[DW-2], val_i[DW-2:0]};
            default:  res_o = val_i[DW-1:0];
        endcase
    end

endmodule

// File: rtl/fxalu_flags.sv
module fxalu_flags
    import fxalu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0]     r_i,
    input  logic              sat_i,
    input  logic              borrow_i,
    output logic [FLAG_W-1:0] flags_o
);
    always_comb begin
        flags_o            = '0;
        flags_o[FL_NORM]   = r_i[DW-1] ^ r_i[DW-2];
        flags_o[FL_BORROW] = borrow_i;
        flags_o[FL_MINUS]  = r_i[DW-1];
        flags_o[FL_ZERO]   = (r_i == '0);
        flags_o[FL_SAT]    = sat_i;
        flags_o[FL_NZ]     = (r_i != '0);
    end

endmodule

// File: rtl/fxalu_core.sv
module fxalu_core
    import fxalu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [3:0]        op_i,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     x_i,
    input  logic [DW-1:0]     y_i,
    output logic [DW-1:0]     res_o,
    output logic              res_valid_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [DW-1:0]     acc_o
);
    localparam int PW = 2 * DW;
    localparam int WW = 2 * DW + 4;
    localparam int SH = DW - 1;

    typedef struct packed {
        logic [DW-1:0]     res;
        logic [FLAG_W-1:0] flags;
        logic [DW-1:0]     acc;
        logic              vld;
    } st_t;

    st_t    st_d, st_q;
    fx_op_e op_e;

    assign op_e = fx_op_e'(op_i);

    // ---------------- operand preparation ----------------
    logic signed [DW:0]   d_ya;
    logic signed [PW-1:0] p_xy;
    logic signed [PW:0]   p_xd;
    logic signed [WW-1:0] a_w, x_w, y_w;
    logic signed [WW-1:0] xy_w, nxy_w, xd_w;
    logic signed [WW-1:0] frac_xy, frac_nxy, frac_xd;

    assign d_ya = $signed({y_i[DW-1], y_i}) - $signed({a_i[DW-1], a_i});

    fxalu_mul #(.AW(DW), .BW(DW)) u_mul_xy (
        .a_i ($signed(x_i)),
        .b_i ($signed(y_i)),
        .p_o (p_xy)
    );

    fxalu_mul #(.AW(DW), .BW(DW+1)) u_mul_xd (
        .a_i ($signed(x_i)),
        .b_i (d_ya),
        .p_o (p_xd)
    );

    assign a_w      = {{(WW-DW){a_i[DW-1]}}, a_i};
    assign x_w      = {{(WW-DW){x_i[DW-1]}}, x_i};
    assign y_w      = {{(WW-DW){y_i[DW-1]}}, y_i};
    assign xy_w     = {{(WW-PW){p_xy[PW-1]}}, p_xy};
    assign nxy_w    = -xy_w;
    assign xd_w     = {{(WW-PW-1){p_xd[PW]}}, p_xd};
    assign frac_xy  = xy_w >>> SH;
    assign frac_nxy = nxy_w >>> SH;
    assign frac_xd  = xd_w >>> SH;

    // ---------------- path selection ----------------
    logic signed [WW-1:0] fit_val;
    fit_e                 fit_mode;
    logic                 use_fit;
    logic [DW-1:0]        sel_r;
    logic                 a_ge_y;

    assign a_ge_y = $signed(a_i) >= $signed(y_i);

    always_comb begin
        fit_val  = a_w;
        fit_mode = FIT_WRAP;
        use_fit  = 1'b1;
        sel_r    = a_i;
        case (op_e)
            OP_MACF:   begin fit_val = a_w + frac_xy;  fit_mode = FIT_SAT;  end
            OP_MACFN:  begin fit_val = a_w + frac_nxy; fit_mode = FIT_SAT;  end
            OP_MACFW:  begin fit_val = a_w + frac_xy;  fit_mode = FIT_WRAP; end
            OP_MACFNW: begin fit_val = a_w + frac_nxy; fit_mode = FIT_WRAP; end
            OP_MACI:   begin fit_val = a_w + xy_w;     fit_mode = FIT_SAT;  end
            OP_MACIW:  begin fit_val = a_w + xy_w;     fit_mode = FIT_W31;  end
            OP_ADD3:   begin fit_val = a_w + x_w + y_w; fit_mode = FIT_SAT; end
            OP_INTERP: begin fit_val = a_w + frac_xd;  fit_mode = FIT_SAT;  end
            OP_MASKX:  begin use_fit = 1'b0; sel_r = (a_i & x_i) ^ y_i;          end
            OP_TSTINV: begin use_fit = 1'b0; sel_r = a_ge_y ? x_i : ~x_i;        end
            OP_SELGE:  begin use_fit = 1'b0; sel_r = a_ge_y ? x_i : y_i;         end
            OP_SELLT:  begin use_fit = 1'b0; sel_r = a_ge_y ? y_i : x_i;         end
            default:   begin fit_val = a_w; fit_mode = FIT_WRAP; end
        endcase
    end

    logic [DW-1:0] fit_res;
    logic          fit_sat;

    fxalu_fit #(.DW(DW), .WW(WW)) u_fit (
        .val_i  (fit_val),
        .mode_i (fit_mode),
        .res_o  (fit_res),
        .sat_o  (fit_sat)
    );

    logic [DW-1:0]     r_now;
    logic              sat_now;
    logic [FLAG_W-1:0] flags_now;

    assign r_now   = use_fit ? fit_res : sel_r;
    assign sat_now = use_fit & fit_sat;

    fxalu_flags #(.DW(DW)) u_flags (
        .r_i      (r_now),
        .sat_i    (sat_now),
        .borrow_i (!a_ge_y),
        .flags_o  (flags_now)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (valid_i) begin
            st_d.vld   = 1'b1;
            st_d.res   = r_now;
            st_d.flags = flags_now;
            case (op_e)
                OP_MVACC:                   st_d.acc = st_q.acc + frac_xy[DW-1:0];
                OP_RSV_C, OP_RSV_D, OP_RSV_F: st_d.acc = st_q.acc;
                default:                    st_d.acc = r_now;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o       = st_q.res;
    assign flags_o     = st_q.flags;
    assign acc_o       = st_q.acc;
    assign res_valid_o = st_q.vld;

    // ---------------- assertions ----------------
    localparam logic [DW-1:0] RMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] RMIN = {1'b1, {(DW-1){1'b0}}};

    p_sat_extreme_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[FL_SAT] |-> (res_o == RMAX || res_o == RMIN));

    p_zero_nz_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (flags_o[FL_ZERO] != flags_o[FL_NZ]));

    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!res_valid_o && $stable(acc_o) && $stable(res_o) && $stable(flags_o)));

    p_rsv_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == OP_RSV_C || op_i == OP_RSV_D || op_i == OP_RSV_F))
        |=> (res_o == $past(a_i) && $stable(acc_o) && !flags_o[FL_SAT]));

    p_mv_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_MVACC) |=> (res_o == $past(a_i)));

    p_sel_nosat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i[3:2] == 2'b10) |=> !flags_o[FL_SAT]);

    p_sel_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (op_i == OP_SELGE || op_i == OP_SELLT))
        |=> (res_o == $past(x_i) || res_o == $past(y_i)));

endmodule

// File: tb/fxalu_core_bench.sv
module fxalu_core_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        valid_i;
    logic [3:0]  op_i;
    logic [31:0] a_i, x_i, y_i;
    logic [31:0] res_o, acc_o;
    logic [15:0] flags_o;
    logic        res_valid_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] e_res = '0, e_acc = '0;
    logic [15:0] e_flags = '0;
    logic        e_vld = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxalu_core u_fxalu_core (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .x_i(x_i), .y_i(y_i), .res_o(res_o),
        .res_valid_o(res_valid_o), .flags_o(flags_o), .acc_o(acc_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference on wide integers
    task automatic model(input logic [3:0] op, input logic [31:0] a, x, y,
                         input logic [31:0] acc_in, output logic [31:0] r,
                         output logic [15:0] f, output logic [31:0] acc_out);
        logic signed [99:0] sa, sx, sy, p, v;
        int  mode;   // 0 clamp, 1 keep 32, 2 keep 31 sign-extended, 3 direct
        bit  sat;
        sa = $signed(a); sx = $signed(x); sy = $signed(y);
        p = sx * sy;
        v = sa; mode = 1; sat = 0; r = a;
        case (op)
            4'h0: begin v = sa + (p >>> 31);    mode = 0; end
            4'h1: begin v = sa + ((-p) >>> 31); mode = 0; end
            4'h2: begin v = sa + (p >>> 31);    mode = 1; end
            4'h3: begin v = sa + ((-p) >>> 31); mode = 1; end
            4'h4: begin v = sa + p;             mode = 0; end
            4'h5: begin v = sa + p;             mode = 2; end
            4'h6: begin v = sa + sx + sy;       mode = 0; end
            4'h8: begin r = (a & x) ^ y;        mode = 3; end
            4'h9: begin r = (sa >= sy) ? x : ~x; mode = 3; end
            4'hA: begin r = (sa >= sy) ? x : y;  mode = 3; end
            4'hB: begin r = (sa <  sy) ? x : y;  mode = 3; end
            4'hE: begin v = sa + ((sx * (sy - sa)) >>> 31); mode = 0; end
            default: begin v = sa; mode = 1; end
        endcase
        if (mode == 0) begin
            if (v > 64'sh7fff_ffff)       begin r = 32'h7fff_ffff; sat = 1; end
            else if (v < -64'sh8000_0000) begin r = 32'h8000_0000; sat = 1; end
            else r = v[31:0];
        end else if (mode == 1) r = v[31:0];
        else if (mode == 2) r = {v[30], v[30:0]};
        f = '0;
        f[0] = r[31] ^ r[30];
        f[1] = (sa < sy);
        f[2] = r[31];
        f[4] = (r == 0);
        f[5] = sat;
        f[8] = (r != 0);
        case (op)
            4'h7: begin v = p >>> 31; acc_out = acc_in + v[31:0]; end
            4'hC, 4'hD, 4'hF: acc_out = acc_in;
            default: acc_out = r;
        endcase
    endtask

    task automatic step(input logic v, input logic [3:0] op,
                        input logic [31:0] a, x, y, input string tag);
        logic [31:0] r, na;
        logic [15:0] f;
        @(negedge clk);
        valid_i = v; op_i = op; a_i = a; x_i = x; y_i = y;
        if (v) begin
            model(op, a, x, y, e_acc, r, f, na);
            e_res = r; e_flags = f; e_acc = na; e_vld = 1'b1;
        end else begin
            e_vld = 1'b0;
        end
        @(posedge clk); #1;
        chk(tag, "res", res_o, e_res);
        chk("R11", "flags", {16'h0, flags_o}, {16'h0, e_flags});
        chk("R12", "acc", acc_o, e_acc);
        chk("R13", "valid", {31'h0, res_valid_o}, {31'h0, e_vld});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; valid_i = 1'b0; op_i = '0; a_i = '0; x_i = '0; y_i = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "res", res_o, 32'h0);
        chk("R1", "flags", {16'h0, flags_o}, 32'h0);
        chk("R1", "acc", acc_o, 32'h0);
        chk("R1", "valid", {31'h0, res_valid_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 fractional saturating
        step(1, 4'h0, 32'h4000_0000, 32'h4000_0000, 32'h4000_0000, "R2");
        step(1, 4'h0, 32'h7fff_ffff, 32'h7fff_ffff, 32'h7fff_ffff, "R2");
        step(1, 4'h0, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, "R2");
        step(1, 4'h1, 32'h8000_0000, 32'h7fff_ffff, 32'h7fff_ffff, "R2");
        step(1, 4'h1, 32'h1000_0000, 32'h0000_0003, 32'h0000_0001, "R2");
        // R3 wrap variants
        step(1, 4'h2, 32'h7fff_ffff, 32'h7fff_ffff, 32'h7fff_ffff, "R3");
        step(1, 4'h3, 32'h8000_0000, 32'h7fff_ffff, 32'h7fff_ffff, "R3");
        step(1, 4'h2, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, "R3");
        // R4 integer products
        step(1, 4'h4, 32'h0000_0001, 32'h0001_0000, 32'h0001_0000, "R4");
        step(1, 4'h4, 32'hffff_fff0, 32'h0000_0004, 32'hffff_fffe, "R4");
        step(1, 4'h4, 32'h8000_0000, 32'hffff_ffff, 32'h0000_0001, "R4");
        step(1, 4'h5, 32'h3fff_ffff, 32'h0000_0001, 32'h0000_0001, "R4");
        step(1, 4'h5, 32'h0000_0000, 32'h0001_0000, 32'h0000_8000, "R4");
        step(1, 4'h5, 32'h0000_0005, 32'h0000_0003, 32'hffff_fffe, "R4");
        // R5 three-input add
        step(1, 4'h6, 32'h0000_0010, 32'h0000_0020, 32'hffff_fff0, "R5");
        step(1, 4'h6, 32'h7000_0000, 32'h1000_0000, 32'h0000_0001, "R5");
        step(1, 4'h6, 32'h8000_0000, 32'hffff_ffff, 32'h0000_0000, "R5");
        // R6 move with side accumulate
        step(1, 4'h8, 32'h0000_0000, 32'h0000_0000, 32'h0000_0100, "R7");
        step(1, 4'h7, 32'h1234_5678, 32'h4000_0000, 32'h4000_0000, "R6");
        step(1, 4'h7, 32'hdead_beef, 32'h4000_0000, 32'h4000_0000, "R6");
        step(1, 4'h7, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000, "R6");
        // R7 bitwise
        step(1, 4'h8, 32'hf0f0_f0f0, 32'hff00_ff00, 32'h0f0f_0f0f, "R7");
        // R8 selects, signed ordering and equality boundary
        step(1, 4'h9, 32'h0000_0005, 32'h1234_5678, 32'h0000_0005, "R8");
        step(1, 4'h9, 32'hffff_ffff, 32'h1234_5678, 32'h0000_0001, "R8");
        step(1, 4'hA, 32'h0000_0001, 32'haaaa_aaaa, 32'h8000_0000, "R8");
        step(1, 4'hA, 32'h8000_0000, 32'haaaa_aaaa, 32'h0000_0001, "R8");
        step(1, 4'hB, 32'h0000_0007, 32'h1111_1111, 32'h0000_0007, "R8");
        step(1, 4'hB, 32'hffff_fff0, 32'h1111_1111, 32'h0000_0007, "R8");
        // R9 interpolation
        step(1, 4'hE, 32'h1000_0000, 32'h4000_0000, 32'h3000_0000, "R9");
        step(1, 4'hE, 32'h8000_0000, 32'h8000_0000, 32'h7fff_ffff, "R9");
        step(1, 4'hE, 32'h7fff_ffff, 32'h7fff_ffff, 32'h8000_0000, "R9");
        step(1, 4'hE, 32'h2000_0000, 32'h0000_0000, 32'h7000_0000, "R9");
        // R10 reserved codes leave the accumulator
        step(1, 4'hC, 32'h0bad_cafe, 32'h7fff_ffff, 32'h7fff_ffff, "R10");
        step(1, 4'hD, 32'h8000_0000, 32'h1, 32'h2, "R10");
        step(1, 4'hF, 32'h0000_0000, 32'h3, 32'h4, "R10");
        // R13 idle cycles hold everything
        step(0, 4'h6, 32'h7fff_ffff, 32'h7fff_ffff, 32'h7fff_ffff, "R13");
        step(0, 4'h0, 32'h1, 32'h1, 32'h1, "R13");
        step(1, 4'h6, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, "R13");
        // R12 back-to-back accumulator load then side accumulate
        step(1, 4'h7, 32'h5555_5555, 32'h7fff_ffff, 32'h7fff_ffff, "R12");
        step(1, 4'h4, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, "R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule